// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block guesses, one cycle ahead, whether a conditional branch at a given fetch address will be taken and where it will go. It keeps a direct-mapped table of branch entries. Each entry holds a valid flag, an address tag, the last taken target and a four-state hysteresis counter for the direction. Fetch presents the program counter together with the decoded branch displacement. The answer appears on registered outputs in the following cycle.

When the table has no matching entry, the direction comes from a static rule: backward branches (negative displacement) are guessed taken and forward ones not taken. The target is then the fetch address plus the sign-extended displacement. When a branch resolves, the execution side reports its address, the real outcome and the real target. That report trains the matching entry, or claims the indexed slot when no entry matches.

A lookup and an update may touch the same slot in the same cycle. The lookup then sees the table as it stood before that update. A reset clears every entry to invalid.

Top module: `btb_predictor`

## Requirements
- R1: A lookup presented with `lk_valid` high in one cycle is answered on `pr_*` after the next rising clock edge, with `pr_valid` high. When no lookup was presented, `pr_valid`, `pr_hit`, `pr_taken` and `pr_target` are all zero.
- R2: The table slot is selected by the PC bits directly above the `BYTE_W` byte-offset bits (`IDX_W = log2(ENTRIES)` bits). A hit needs a valid slot whose stored tag equals the PC bits above the index. PC byte-offset bits take no part in the match.
- R3: After reset, every slot is invalid, so every lookup misses until an update has written its slot.
- R4: On a miss, `pr_taken` is 1 when bit `OFS_W-1` of the displacement is 1 (negative), and 0 otherwise, zero included.
- R5: On a miss, `pr_target` is the looked-up PC plus the displacement sign-extended to `PC_W` bits, taken modulo 2^PC_W.
- R6: An update that misses writes the slot with its tag and the reported target. The direction state becomes weak-taken (2'b10) for a taken outcome and weak-not-taken (2'b01) otherwise.
- R7: An update that hits steps the direction state, encoded strong-not-taken 2'b00, weak-not-taken 2'b01, weak-taken 2'b10 and strong-taken 2'b11. A taken outcome steps it one place toward 2'b11 and a not-taken outcome one place toward 2'b00. The state saturates at both ends.
- R8: On a hit, `pr_taken` is bit 1 of the slot's direction state (taken for 2'b11 and 2'b10), and `pr_target` is the slot's stored target.
- R9: An update that hits replaces the stored target only when the outcome is taken. A not-taken outcome leaves the target unchanged.
- R10: When an update and a lookup address the same slot in the same cycle, the lookup answer reflects the slot contents from before that update. The update is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all slots to invalid |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Fetch address of the branch being looked up |
| lk_offset | input | OFS_W | Decoded signed branch displacement |
| up_valid | input | 1 | Resolved-branch report this cycle |
| up_pc_word | input | PC_W-BYTE_W | Resolved branch address with its byte-offset bits dropped |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_target | input | PC_W | Resolved branch target |
| pr_valid | output | 1 | Registered answer is present |
| pr_hit | output | 1 | Answer came from a matching table slot |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_target | output | PC_W | Predicted target address |

## Verification
The two functions that can land in one cycle are a lookup and a training update on the same slot. The random phase draws addresses from a pool of only a few slots and tags, so such coincidences, aliasing tags and repeated training of one slot all occur often. A directed case also forces the collision on purpose. The bench model answers each lookup from its table before applying that cycle's update, so a design that forwards the new contents, or loses the update, shows a mismatch in the answer or in the lookup that follows.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Direction hysteresis state; bit 1 is the predicted direction.
    typedef enum logic [1:0] {
        DIR_SNT = 2'b00,
        DIR_WNT = 2'b01,
        DIR_WT  = 2'b10,
        DIR_ST  = 2'b11
    } dir_e;

    // One saturating step toward the resolved outcome.
    function automatic dir_e dir_step(input dir_e cur, input logic taken);
        dir_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != DIR_ST) nxt = dir_e'(cur + 2'd1);
        end else begin
            if (cur != DIR_SNT) nxt = dir_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // State given to a freshly claimed slot.
    function automatic dir_e dir_alloc(input logic taken);
        return taken ? DIR_WT : DIR_WNT;
    endfunction

    function automatic logic dir_predicts_taken(input dir_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int WORD_W = 30,
    parameter int IDX_W  = 9,
    localparam int TAG_W = WORD_W - IDX_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // Index sits right above the dropped byte offset, tag above the index.
    always_comb begin
        idx = word[IDX_W-1:0];
        tag = word[WORD_W-1:IDX_W];
    end

endmodule

// File: rtl/btb_fallback.sv
module btb_fallback #(
    parameter int PC_W  = 32,
    parameter int OFS_W = 16,
    localparam int EXT_W = PC_W - OFS_W
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFS_W-1:0] offset,
    output logic             taken,
    output logic [PC_W-1:0]  target
);

    logic [PC_W-1:0] offset_ext;

    always_comb begin
        offset_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
        // Backward displacement guessed taken, forward guessed not taken.
        taken      = offset[OFS_W-1];
        target     = pc + offset_ext;
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 512,
    parameter int TAG_W   = 21,
    parameter int PC_W    = 32,
    parameter int NRD     = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    // read ports, combinational, contents as of before this edge's write
    input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NRD-1:0]              rd_valid,
    output logic [NRD-1:0][TAG_W-1:0]   rd_tag,
    output logic [NRD-1:0][PC_W-1:0]    rd_target,
    output logic [NRD-1:0][1:0]         rd_dir,
    // single write port
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [PC_W-1:0]             wr_target,
    input  dir_e                        wr_dir
);

    logic [ENTRIES-1:0] valid_d;
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [PC_W-1:0]    target_q [ENTRIES];
    dir_e               dir_q    [ENTRIES];

    // Valid flags carry reset; the payload arrays need none.
    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            target_q[wr_idx] <= wr_target;
            dir_q[wr_idx]    <= wr_dir;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_valid[p]  = valid_q[rd_idx[p]];
            rd_tag[p]    = tag_q[rd_idx[p]];
            rd_target[p] = target_q[rd_idx[p]];
            rd_dir[p]    = dir_q[rd_idx[p]];
        end
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ENTRIES = 512,
    parameter int PC_W    = 32,
    parameter int BYTE_W  = 2,
    parameter int OFS_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int WORD_W = PC_W - BYTE_W,
    localparam int TAG_W  = WORD_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [OFS_W-1:0]  lk_offset,
    input  logic              up_valid,
    input  logic [WORD_W-1:0] up_pc_word,
    input  logic              up_taken,
    input  logic [PC_W-1:0]   up_target,
    output logic              pr_valid,
    output logic              pr_hit,
    output logic              pr_taken,
    output logic [PC_W-1:0]   pr_target
);

    localparam int RD_LK = 0;
    localparam int RD_UP = 1;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            taken;
        logic [PC_W-1:0] target;
    } pred_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
        dir_e             dir;
    } wr_t;

    pred_t pred_d, pred_q;
    wr_t   wr_d;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;

    logic [1:0][IDX_W-1:0] rd_idx;
    logic [1:0]            rd_valid;
    logic [1:0][TAG_W-1:0] rd_tag;
    logic [1:0][PC_W-1:0]  rd_target;
    logic [1:0][1:0]       rd_dir;

    logic            fb_taken;
    logic [PC_W-1:0] fb_target;

    btb_pc_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_lk_split (
        .word (lk_pc[PC_W-1:BYTE_W]),
        .idx  (lk_idx),
        .tag  (lk_tag)
    );

    btb_pc_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_up_split (
        .word (up_pc_word),
        .idx  (up_idx),
        .tag  (up_tag)
    );

    btb_fallback #(.PC_W(PC_W), .OFS_W(OFS_W)) u_fallback (
        .pc     (lk_pc),
        .offset (lk_offset),
        .taken  (fb_taken),
        .target (fb_target)
    );

    always_comb begin
        rd_idx[RD_LK] = lk_idx;
        rd_idx[RD_UP] = up_idx;
    end

    btb_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .PC_W    (PC_W),
        .NRD     (2)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .rd_dir    (rd_dir),
        .wr_en     (wr_d.en),
        .wr_idx    (wr_d.idx),
        .wr_tag    (wr_d.tag),
        .wr_target (wr_d.target),
        .wr_dir    (wr_d.dir)
    );

    // Lookup: the store is read before this edge's write lands, so a
    // same-slot update is not seen by this answer.
    always_comb begin
        logic lk_hit;
        lk_hit = rd_valid[RD_LK] && (rd_tag[RD_LK] == lk_tag);
        pred_d = '0;
        if (lk_valid) begin
            pred_d.valid  = 1'b1;
            pred_d.hit    = lk_hit;
            pred_d.taken  = lk_hit ? dir_predicts_taken(dir_e'(rd_dir[RD_LK])) : fb_taken;
            pred_d.target = lk_hit ? rd_target[RD_LK] : fb_target;
        end
    end

    // Update: train a matching slot or claim the indexed one.
    always_comb begin
        logic up_hit;
        up_hit      = rd_valid[RD_UP] && (rd_tag[RD_UP] == up_tag);
        wr_d.en     = up_valid;
        wr_d.idx    = up_idx;
        wr_d.tag    = up_tag;
        if (up_hit) begin
            wr_d.dir    = dir_step(dir_e'(rd_dir[RD_UP]), up_taken);
            wr_d.target = up_taken ? up_target : rd_target[RD_UP];
        end else begin
            wr_d.dir    = dir_alloc(up_taken);
            wr_d.target = up_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pred_q <= '0;
        else        pred_q <= pred_d;
    end

    assign pr_valid  = pred_q.valid;
    assign pr_hit    = pred_q.hit;
    assign pr_taken  = pred_q.taken;
    assign pr_target = pred_q.target;

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int PC_W   = 32,
    parameter int BYTE_W = 2,
    parameter int OFS_W  = 16,
    localparam int WORD_W = PC_W - BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [PC_W-1:0]   lk_pc,
    input logic [OFS_W-1:0]  lk_offset,
    input logic              up_valid,
    input logic [WORD_W-1:0] up_pc_word,
    input logic              up_taken,
    input logic [PC_W-1:0]   up_target,
    input logic              pr_valid,
    input logic              pr_hit,
    input logic              pr_taken,
    input logic [PC_W-1:0]   pr_target
);

    logic [1:0]      seen_q;
    logic [PC_W-1:0] off_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             seen_q <= 2'd0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    assign off_ext = {{(PC_W-OFS_W){lk_offset[OFS_W-1]}}, lk_offset};

    p_answer_follows_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0) |-> (pr_valid == $past(lk_valid)));

    p_idle_outputs_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pr_valid |-> (!pr_hit && !pr_taken && (pr_target == '0)));

    p_miss_direction_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen_q != 2'd0) && pr_valid && !pr_hit) |-> (pr_taken == $past(lk_offset[OFS_W-1])));

    p_miss_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen_q != 2'd0) && pr_valid && !pr_hit) |-> (pr_target == $past(lk_pc) + $past(off_ext)));

    // Taken training followed by a lookup of the same address must hit with that target (R6/R9).
    p_trained_slot_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen_q == 2'd3) && $past(up_valid, 2) && $past(up_taken, 2) && !$past(up_valid)
         && $past(lk_valid) && ($past(lk_pc[PC_W-1:BYTE_W]) == $past(up_pc_word, 2)))
        |-> (pr_hit && (pr_target == $past(up_target, 2))));

endmodule

bind btb_predictor btb_predictor_chk #(
    .PC_W   (PC_W),
    .BYTE_W (BYTE_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_pc      (lk_pc),
    .lk_offset  (lk_offset),
    .up_valid   (up_valid),
    .up_pc_word (up_pc_word),
    .up_taken   (up_taken),
    .up_target  (up_target),
    .pr_valid   (pr_valid),
    .pr_hit     (pr_hit),
    .pr_taken   (pr_taken),
    .pr_target  (pr_target)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

    localparam int ENTRIES = 512;
    localparam int PC_W    = 32;
    localparam int BYTE_W  = 2;
    localparam int OFS_W   = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int WORD_W  = PC_W - BYTE_W;
    localparam int TAG_W   = WORD_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [PC_W-1:0]   lk_pc = '0;
    logic [OFS_W-1:0]  lk_offset = '0;
    logic              up_valid = 1'b0;
    logic [WORD_W-1:0] up_pc_word = '0;
    logic              up_taken = 1'b0;
    logic [PC_W-1:0]   up_target = '0;
    logic              pr_valid, pr_hit, pr_taken;
    logic [PC_W-1:0]   pr_target;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    btb_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W), .BYTE_W(BYTE_W), .OFS_W(OFS_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_offset(lk_offset),
        .up_valid(up_valid), .up_pc_word(up_pc_word), .up_taken(up_taken), .up_target(up_target),
        .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_target(pr_target)
    );

    // Reference table, built from the requirements.
    bit              m_valid  [ENTRIES];
    logic [TAG_W-1:0] m_tag    [ENTRIES];
    logic [PC_W-1:0] m_target [ENTRIES];
    logic [1:0]      m_dir    [ENTRIES];

    typedef struct packed {
        logic            v;
        logic            h;
        logic            t;
        logic [PC_W-1:0] tg;
    } ans_t;

    function automatic ans_t model_lookup(input logic lv, input logic [PC_W-1:0] pc,
                                          input logic [OFS_W-1:0] off);
        ans_t a;
        int   idx;
        a = '0;
        if (!lv) return a;
        idx = int'(pc[BYTE_W +: IDX_W]);
        a.v = 1'b1;
        if (m_valid[idx] && m_tag[idx] == pc[PC_W-1 -: TAG_W]) begin
            a.h  = 1'b1;
            a.t  = m_dir[idx][1];
            a.tg = m_target[idx];
        end else begin
            a.t  = off[OFS_W-1];
            a.tg = pc + {{(PC_W-OFS_W){off[OFS_W-1]}}, off};
        end
        return a;
    endfunction

    function automatic void model_update(input logic [WORD_W-1:0] w, input logic tk,
                                         input logic [PC_W-1:0] tgt);
        int idx;
        idx = int'(w[IDX_W-1:0]);
        if (m_valid[idx] && m_tag[idx] == w[WORD_W-1:IDX_W]) begin
            if (tk) begin
                if (m_dir[idx] != 2'b11) m_dir[idx] = m_dir[idx] + 2'd1;
                m_target[idx] = tgt;
            end else if (m_dir[idx] != 2'b00) begin
                m_dir[idx] = m_dir[idx] - 2'd1;
            end
        end else begin
            m_valid[idx]  = 1'b1;
            m_tag[idx]    = w[WORD_W-1:IDX_W];
            m_target[idx] = tgt;
            m_dir[idx]    = tk ? 2'b10 : 2'b01;
        end
    endfunction

    task automatic check(input string req, input ans_t act, input ans_t exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got v=%0b h=%0b t=%0b tgt=%h, expected v=%0b h=%0b t=%0b tgt=%h",
                     req, act.v, act.h, act.t, act.tg, exp.v, exp.h, exp.t, exp.tg);
        end
    endtask

    // One cycle: drive at negedge, answer is sampled at the following negedge.
    task automatic step(input logic lv, input logic [PC_W-1:0] pc, input logic [OFS_W-1:0] off,
                        input logic uv, input logic [WORD_W-1:0] uw, input logic ut,
                        input logic [PC_W-1:0] utg, input string req);
        ans_t  exp, act;
        string tag;
        lk_valid = lv; lk_pc = pc; lk_offset = off;
        up_valid = uv; up_pc_word = uw; up_taken = ut; up_target = utg;
        exp = model_lookup(lv, pc, off);   // pre-update view (R10)
        if (uv) model_update(uw, ut, utg);
        @(posedge clk);
        @(negedge clk);
        act = {pr_valid, pr_hit, pr_taken, pr_target};
        tag = req;
        if (tag == "") tag = !exp.v ? "R1" : (exp.h ? "R8" : "R4/R5");
        check(tag, act, exp);
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input logic [OFS_W-1:0] off, input string req);
        step(1'b1, pc, off, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic train(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt);
        step(1'b0, '0, '0, 1'b1, pc[PC_W-1:BYTE_W], tk, tgt, "R1");
    endtask

    function automatic logic [PC_W-1:0] pool_pc();
        logic [PC_W-1:0] p;
        p = 32'h4000_0000;
        p = p | (PC_W'($urandom_range(0, 2)) << (BYTE_W + IDX_W));
        p = p | (PC_W'($urandom_range(0, 7)) << BYTE_W);
        p = p | PC_W'($urandom_range(0, 3));
        return p;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] pa, pq;
        ans_t zero;
        void'($urandom(32'd1234));
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
        zero = '0;

        repeat (3) @(negedge clk);
        check("R1 reset outputs", {pr_valid, pr_hit, pr_taken, pr_target}, zero);
        rst_n = 1'b1;
        @(negedge clk);

        pa = 32'h0001_2348;
        pq = pa ^ 32'h0010_0000;                         // same slot, other tag

        // R3: fresh table misses everywhere
        look(pa, 16'h0010, "R3");
        look(32'h0000_0000, 16'h0000, "R3");
        look(32'hFFFF_FFFC, 16'h0008, "R3/R5 wrap");
        // R4/R5: static rule and fallback target
        look(pa, 16'hFFF0, "R4 negative");
        look(pa, 16'h0000, "R4 zero");
        look(pa, 16'h8000, "R5 most negative");
        step(1'b0, pa, 16'h1234, 1'b0, '0, 1'b0, '0, "R1 idle");

        // R6: claim on not-taken, then weak-not-taken predicts not taken
        train(pa, 1'b0, 32'h0000_1000);
        look(pa, 16'hFFF0, "R6 alloc WNT");
        // R7: walk the counter and hit both ends
        train(pa, 1'b1, 32'h0000_2000);
        look(pa, 16'h0, "R7 WNT->WT");
        train(pa, 1'b1, 32'h0000_2000);
        train(pa, 1'b1, 32'h0000_2000);
        train(pa, 1'b0, 32'h0000_2000);
        look(pa, 16'h0, "R7 ST saturate then WT");
        train(pa, 1'b0, 32'h0);
        train(pa, 1'b0, 32'h0);
        train(pa, 1'b0, 32'h0);
        train(pa, 1'b1, 32'h0000_3000);
        look(pa, 16'hFFF0, "R7 SNT saturate then WNT");
        // R9: not-taken keeps target
        train(pa, 1'b1, 32'h0000_4000);
        train(pa, 1'b0, 32'h0000_5000);
        look(pa, 16'h0, "R9 target kept");
        // R2: alias misses, byte bits ignored
        look(pq, 16'hFFF0, "R2 alias miss");
        look(pa | 32'h3, 16'h0, "R2 byte bits");
        // R10: collide lookup and update on one slot
        step(1'b1, pa, 16'h0, 1'b1, pa[PC_W-1:BYTE_W], 1'b1, 32'h0000_6000, "R10 same cycle");
        look(pa, 16'h0, "R10 next cycle");
        step(1'b1, pq, 16'h0, 1'b1, pq[PC_W-1:BYTE_W], 1'b0, 32'h0000_7000, "R10 claim collide");
        look(pq, 16'h0, "R6 alias claim");

        // Random mix over a small pool of slots and tags
        for (int n = 0; n < 4000; n++) begin
            logic [PC_W-1:0] lpc, upc;
            lpc = pool_pc();
            upc = ($urandom_range(0, 3) == 0) ? lpc : pool_pc();
            step($urandom_range(0, 99) < 85, lpc, OFS_W'($urandom()),
                 $urandom_range(0, 99) < 60, upc[PC_W-1:BYTE_W], 1'($urandom()),
                 $urandom(), "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule